// File: doc/BRIEF.md
# Multi-mode 16-bit PWM timer

The block is a 16-bit timer/counter that drives two pulse-width-modulated pins from one shared count. A 4-bit waveform-mode field picks one of four counting schemes: a free-running count, clear-on-match, single-slope PWM or dual-slope PWM. The same field also picks where the period limit (TOP) comes from: a fixed value, the active compare register of channel A, or a separate period register. A 3-bit clock-select field steps the count on every system clock, on every 8th, 64th, 256th or 1024th clock, or not at all.

Software programs the block through a one-cycle synchronous write port: a control word, two compare values and a period value. In PWM modes each compare value passes through a holding buffer and moves into use only at a point in the count that depends on the mode, so a duty change never cuts a pulse short. Each pin has a 2-bit output-mode field that chooses between off, toggle, non-inverting and inverting behaviour.

Top module: `pwm16_timer`

## Requirements
- R1: Control word (address 0) fields: bits [3:0] mode, [6:4] clock select, [9:8] out-mode A, [11:10] out-mode B. In mode 0 the count advances by one per timer step and wraps from 0xFFFF to 0. In modes 0, 4, 12 and 13, on a step where the count equals a channel's active compare value, out-mode 1 toggles the pin, 2 clears it and 3 sets it. Out-mode 0 holds the pin low.
- R2: Single-slope modes 5, 6 and 7 use fixed TOP values 0x00FF, 0x01FF and 0x03FF. Mode 14 takes TOP from the period register and mode 15 takes it from channel A's active compare value. On a step where the count is at or above TOP, the next count is 0. Otherwise the count adds one.
- R3: Dual-slope modes 1, 2 and 3 use fixed TOP values 0x00FF, 0x01FF and 0x03FF. Modes 8 and 10 take TOP from the period register, and modes 9 and 11 take it from channel A's active compare value. The count rises to TOP and then falls to 0, so one period lasts 2·TOP steps.
- R4: Clock select 1, 2, 3, 4 and 5 give one timer step every 1, 8, 64, 256 and 1024 system clocks. Clock select 0, 6 and 7 stop the count. After a write that moves the field from a stopped value to a running value, the count first changes exactly N clocks after the write edge.
- R5: Mode 13 is reserved and counts exactly as mode 0.
- R6: Clear-on-match modes 4 (TOP is channel A's compare value) and 12 (TOP is the period register) return the count to 0 on the step after it equals TOP. Compare writes in these modes take effect at once. A TOP below the current count lets the count run on to 0xFFFF and wrap before the next match.
- R7: In the PWM modes that take TOP from channel A (9, 11 and 15), pin A stays low.
- R8: In PWM modes, out-mode 2 drives a pin high while count < compare value, and out-mode 3 drives the inverse. A compare value of 0 gives a constant low level (out-mode 2). A compare value at or above TOP gives a constant high level. Out-modes 0 and 1 keep the pin low.
- R9: In PWM modes, writes to compare A (address 1) or compare B (address 2) fill a buffer. The buffer moves into the active register on the step that turns the count down at TOP in modes 1, 2, 3, 10 and 11. It moves on the step that wraps to 0 in modes 5, 6, 7, 14 and 15, and on the step that leaves 0 on the way down in modes 8 and 9.
- R10: The period register (address 3) is written directly. Reset clears all registers, the count, and both pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Register select: 0 control, 1 compare A, 2 compare B, 3 period |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current timer count |
| out_a | output | 1 | Waveform pin A |
| out_b | output | 1 | Waveform pin B |

## Verification
The count, the toggle flops and the active compare values are registers, and both pins decode from them without further delay. Every result is therefore visible in the cycle after the rising edge on which its timer step or write lands, and a buffered compare value appears only after the transfer step. A timer step lands N system clocks after the prescaler restarts, so the first count change after a start comes N edges after the control write. The bench steps its own model on each rising edge and compares count and pins on the following falling edge. Directed windows are timed by counting edges from the write edge or by waiting for a named count value.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 10;
  localparam int CTRL_W = 12;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_CMPA = 3'd1;
  localparam logic [2:0] ADDR_PER  = 3'd3;

  typedef enum logic [1:0] {K_NORMAL, K_CTC, K_FAST, K_DUAL} kind_e;
  typedef enum logic [1:0] {S_FIXED, S_CMPA, S_PER}          src_e;
  typedef enum logic [1:0] {U_IMM, U_TOP, U_BOT}             upd_e;

  typedef struct packed {
    kind_e              kind;
    src_e               src;
    upd_e               upd;
    logic [CNT_W-1:0]   fixed_top;
  } mode_t;

  // 8, 9 or 10 bit limit picked by the low two mode bits
  function automatic logic [CNT_W-1:0] fixed_top_of(input logic [3:0] w);
    return (CNT_W'(1) << (7 + int'(w[1:0]))) - CNT_W'(1);
  endfunction

  function automatic mode_t decode_mode(input logic [3:0] w);
    mode_t m;
    m.kind      = K_NORMAL;
    m.src       = S_FIXED;
    m.upd       = U_IMM;
    m.fixed_top = '1;
    case (w)
      4'd1, 4'd2, 4'd3: begin m.kind = K_DUAL; m.upd = U_TOP; m.fixed_top = fixed_top_of(w); end
      4'd4:             begin m.kind = K_CTC;  m.src = S_CMPA; end
      4'd5, 4'd6, 4'd7: begin m.kind = K_FAST; m.upd = U_BOT; m.fixed_top = fixed_top_of(w); end
      4'd8:             begin m.kind = K_DUAL; m.src = S_PER;  m.upd = U_BOT; end
      4'd9:             begin m.kind = K_DUAL; m.src = S_CMPA; m.upd = U_BOT; end
      4'd10:            begin m.kind = K_DUAL; m.src = S_PER;  m.upd = U_TOP; end
      4'd11:            begin m.kind = K_DUAL; m.src = S_CMPA; m.upd = U_TOP; end
      4'd12:            begin m.kind = K_CTC;  m.src = S_PER;  end
      4'd14:            begin m.kind = K_FAST; m.src = S_PER;  m.upd = U_BOT; end
      4'd15:            begin m.kind = K_FAST; m.src = S_CMPA; m.upd = U_BOT; end
      default:          ; // 0 and reserved 13: free count
    endcase
    return m;
  endfunction

  function automatic logic [PRE_W:0] div_of(input logic [2:0] cs);
    case (cs)
      3'd1:    return (PRE_W+1)'(1);
      3'd2:    return (PRE_W+1)'(8);
      3'd3:    return (PRE_W+1)'(64);
      3'd4:    return (PRE_W+1)'(256);
      3'd5:    return (PRE_W+1)'(1024);
      default: return '0;
    endcase
  endfunction

  // non-inverted duty level; compare at/above TOP pins high, zero pins low
  function automatic logic pwm_level(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] cmp,
                                     input logic [CNT_W-1:0] top);
    return (cmp >= top) || (cnt < cmp);
  endfunction
endpackage

// File: rtl/pwm16_prescaler.sv
module pwm16_prescaler
  import pwm16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cs,
  output logic       tick
);
  logic [PRE_W:0]   div;
  logic [PRE_W-1:0] pre;
  logic             run;

  assign div  = div_of(cs);
  assign run  = (div != '0);
  assign tick = run && ({1'b0, pre} >= (div - 1'b1));

  // held at zero while stopped, so a restart begins a full interval
  always_ff @(posedge clk) begin
    if (!rst_n)            pre <= '0;
    else if (!run || tick) pre <= '0;
    else                   pre <= pre + 1'b1;
  end
endmodule

// File: rtl/pwm16_counter.sv
module pwm16_counter
  import pwm16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  kind_e            kind,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             dn,
  output logic             at_top,
  output logic             at_bot
);
  logic             at_max;
  logic [CNT_W-1:0] cnt_nx;
  logic             dn_nx;

  assign at_max = (cnt >= top);
  assign at_top = tick && (kind == K_DUAL) && !dn && at_max;
  assign at_bot = tick && (((kind == K_FAST) && at_max) ||
                           ((kind == K_DUAL) && dn && (cnt == '0)));

  always_comb begin
    cnt_nx = cnt;
    dn_nx  = dn;
    if (tick) begin
      dn_nx = 1'b0;
      case (kind)
        K_NORMAL: cnt_nx = cnt + 1'b1;
        K_CTC:    cnt_nx = (cnt == top) ? '0 : cnt + 1'b1;
        K_FAST:   cnt_nx = at_max ? '0 : cnt + 1'b1;
        K_DUAL: begin
          if (!dn) begin
            if (!at_max)           cnt_nx = cnt + 1'b1;
            else if (top == '0)    cnt_nx = '0;
            else begin dn_nx = 1'b1; cnt_nx = top - 1'b1; end
          end else if (cnt == '0) begin
            cnt_nx = (top == '0) ? '0 : CNT_W'(1);
          end else begin
            dn_nx  = 1'b1;
            cnt_nx = cnt - 1'b1;
          end
        end
        default: cnt_nx = cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      dn  <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      dn  <= dn_nx;
    end
  end
endmodule

// File: rtl/pwm16_channel.sv
module pwm16_channel
  import pwm16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  upd_e             upd,
  input  kind_e            kind,
  input  logic             tick,
  input  logic             at_top,
  input  logic             at_bot,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] top,
  input  logic [1:0]       com,
  input  logic             mute,
  output logic [CNT_W-1:0] act,
  output logic             xfer,
  output logic             pin
);
  logic [CNT_W-1:0] hold;
  logic             flop;
  logic             pwm;
  logic             lvl;

  assign pwm  = (kind == K_FAST) || (kind == K_DUAL);
  assign xfer = ((upd == U_TOP) && at_top) || ((upd == U_BOT) && at_bot);
  assign lvl  = pwm_level(cnt, act, top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      act  <= '0;
    end else begin
      if (wr) hold <= wdata;
      if (wr && (upd == U_IMM)) act <= wdata;
      else if (xfer)            act <= hold;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flop <= 1'b0;
    else if (tick && !pwm && (cnt == act)) begin
      case (com)
        2'd1:    flop <= ~flop;
        2'd2:    flop <= 1'b0;
        2'd3:    flop <= 1'b1;
        default: flop <= flop;
      endcase
    end
  end

  always_comb begin
    if (pwm) pin = (mute || !com[1]) ? 1'b0 : (lvl ^ com[0]);
    else     pin = (com == 2'd0) ? 1'b0 : flop;
  end
endmodule

// File: rtl/pwm16_timer.sv
module pwm16_timer
  import pwm16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             out_a,
  output logic             out_b
);
  localparam int NCH = 2;

  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  per;
  mode_t             md;
  kind_e             cur_kind;
  src_e              cur_src;
  upd_e              cur_upd;
  logic [CNT_W-1:0]  top_val;
  logic              tick;
  logic              dir_dn;
  logic              at_top;
  logic              at_bot;
  logic [CNT_W-1:0]  act  [NCH];
  logic              xfer [NCH];
  logic              pin  [NCH];
  logic [CNT_W-1:0]  act_b;
  logic              xfer_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      per  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL) ctrl <= wr_data[CTRL_W-1:0];
      if (wr_addr == ADDR_PER)  per  <= wr_data;
    end
  end

  assign md       = decode_mode(ctrl[3:0]);
  assign cur_kind = md.kind;
  assign cur_src  = md.src;
  assign cur_upd  = md.upd;

  always_comb begin
    case (md.src)
      S_CMPA:  top_val = act[0];
      S_PER:   top_val = per;
      default: top_val = md.fixed_top;
    endcase
  end

  pwm16_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .cs   (ctrl[6:4]),
    .tick (tick)
  );

  pwm16_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .kind  (md.kind),
    .top   (top_val),
    .cnt   (count),
    .dn    (dir_dn),
    .at_top(at_top),
    .at_bot(at_bot)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [2:0] MY_ADDR = ADDR_CMPA + 3'(ch);
    pwm16_channel u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_en && (wr_addr == MY_ADDR)),
      .wdata (wr_data),
      .upd   (md.upd),
      .kind  (md.kind),
      .tick  (tick),
      .at_top(at_top),
      .at_bot(at_bot),
      .cnt   (count),
      .top   (top_val),
      .com   (ctrl[8+2*ch +: 2]),
      .mute  ((ch == 0) && (md.src == S_CMPA)),
      .act   (act[ch]),
      .xfer  (xfer[ch]),
      .pin   (pin[ch])
    );
  end

  assign out_a  = pin[0];
  assign out_b  = pin[1];
  assign act_b  = act[1];
  assign xfer_b = xfer[1];
endmodule

// File: rtl/pwm16_timer_chk.sv
module pwm16_timer_chk
  import pwm16_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             dn,
  input kind_e            kind,
  input src_e             src,
  input upd_e             upd,
  input logic [CNT_W-1:0] top,
  input logic [3:0]       wgm,
  input logic             pin_a,
  input logic [CNT_W-1:0] act_b,
  input logic             xfer_b
);
  p_fast_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_FAST && tick && cnt >= top) |=> (cnt == '0));

  p_dual_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_DUAL && tick && !dn && cnt >= top && top != '0) |=> dn);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  p_reserved_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wgm == 4'd13 && tick) |=> (cnt == $past(cnt) + 1'b1));

  p_ctc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_CTC && tick && cnt == top) |=> (cnt == '0));

  p_a_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == K_FAST || kind == K_DUAL) && src == S_CMPA) |-> !pin_a);

  p_buffer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd != U_IMM && !xfer_b) |=> $stable(act_b));
endmodule

bind pwm16_timer pwm16_timer_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick),
  .cnt   (count),
  .dn    (dir_dn),
  .kind  (cur_kind),
  .src   (cur_src),
  .upd   (cur_upd),
  .top   (top_val),
  .wgm   (ctrl[3:0]),
  .pin_a (out_a),
  .act_b (act_b),
  .xfer_b(xfer_b)
);

// File: tb/pwm16_timer_tb.sv
module pwm16_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'd0;
  wire  [15:0] count;
  wire         out_a;
  wire         out_b;

  int n_chk = 0;
  int n_bad = 0;
  bit live  = 1'b0;

  always #4 clk = ~clk;

  pwm16_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .out_a(out_a), .out_b(out_b)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      if (n_bad < 40) $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model, restated from the requirements
  bit [15:0] m_cnt, m_per;
  bit        m_dn;
  bit [11:0] m_ctrl;
  int        m_pre;
  bit [15:0] m_act [2];
  bit [15:0] m_buf [2];
  bit        m_fl  [2];

  function automatic int f_div(input int cs);
    case (cs)
      1: return 1;  2: return 8;  3: return 64;
      4: return 256; 5: return 1024;
      default: return 0;
    endcase
  endfunction

  // 0 free, 1 clear-on-match, 2 single slope, 3 dual slope
  function automatic int f_class(input int w);
    if (w inside {1, 2, 3, 8, 9, 10, 11}) return 3;
    if (w inside {5, 6, 7, 14, 15})       return 2;
    if (w inside {4, 12})                 return 1;
    return 0;
  endfunction

  function automatic int f_src(input int w);
    if (w inside {4, 9, 11, 15})  return 1;
    if (w inside {8, 10, 12, 14}) return 2;
    return 0;
  endfunction

  function automatic int f_top(input int w);
    if (f_src(w) == 1) return int'(m_act[0]);
    if (f_src(w) == 2) return int'(m_per);
    if (w inside {1, 5}) return 255;
    if (w inside {2, 6}) return 511;
    if (w inside {3, 7}) return 1023;
    return 65535;
  endfunction

  function automatic int f_upd(input int w);
    if (f_class(w) < 2)               return 0;
    if (w inside {1, 2, 3, 10, 11})   return 1;
    return 2;
  endfunction

  function automatic bit f_pin(input int ch);
    int w, com, top;
    bit lvl;
    w   = int'(m_ctrl[3:0]);
    com = int'(m_ctrl[8+2*ch +: 2]);
    top = f_top(w);
    if (f_class(w) >= 2) begin
      if (com < 2 || (ch == 0 && f_src(w) == 1)) return 1'b0;
      lvl = (int'(m_act[ch]) >= top) || (m_cnt < m_act[ch]);
      return (com == 3) ? !lvl : lvl;
    end
    return (com == 0) ? 1'b0 : m_fl[ch];
  endfunction

  always @(posedge clk) begin
    int w, cl, top, dv, com;
    bit tk, tev, bev, nd;
    bit [15:0] nc;
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_dn = 0; m_ctrl = 0; m_pre = 0;
      for (int c = 0; c < 2; c++) begin m_act[c] = 0; m_buf[c] = 0; m_fl[c] = 0; end
    end else begin
      w   = int'(m_ctrl[3:0]);
      cl  = f_class(w);
      top = f_top(w);
      dv  = f_div(int'(m_ctrl[6:4]));
      tk  = (dv != 0) && (m_pre >= dv - 1);
      m_pre = (dv == 0 || tk) ? 0 : m_pre + 1;
      tev = tk && cl == 3 && !m_dn && int'(m_cnt) >= top;
      bev = tk && ((cl == 2 && int'(m_cnt) >= top) || (cl == 3 && m_dn && m_cnt == 0));
      nc = m_cnt;
      nd = m_dn;
      if (tk) begin
        for (int c = 0; c < 2; c++) begin
          com = int'(m_ctrl[8+2*c +: 2]);
          if (cl < 2 && m_cnt == m_act[c]) begin
            if (com == 1) m_fl[c] = !m_fl[c];
            if (com == 2) m_fl[c] = 1'b0;
            if (com == 3) m_fl[c] = 1'b1;
          end
        end
        nd = 1'b0;
        case (cl)
          0: nc = m_cnt + 16'd1;
          1: nc = (int'(m_cnt) == top) ? 16'd0 : m_cnt + 16'd1;
          2: nc = (int'(m_cnt) >= top) ? 16'd0 : m_cnt + 16'd1;
          default: begin
            if (!m_dn) begin
              if (int'(m_cnt) < top) nc = m_cnt + 16'd1;
              else if (top == 0)     nc = 16'd0;
              else begin nd = 1'b1; nc = 16'(top - 1); end
            end else if (m_cnt == 0) begin
              nc = (top == 0) ? 16'd0 : 16'd1;
            end else begin
              nd = 1'b1; nc = m_cnt - 16'd1;
            end
          end
        endcase
      end
      for (int c = 0; c < 2; c++)
        if ((f_upd(w) == 1 && tev) || (f_upd(w) == 2 && bev)) m_act[c] = m_buf[c];
      if (wr_en) begin
        if (wr_addr == 3'd0) m_ctrl = wr_data[11:0];
        if (wr_addr == 3'd3) m_per = wr_data;
        if (wr_addr == 3'd1 || wr_addr == 3'd2) begin
          m_buf[wr_addr - 3'd1] = wr_data;
          if (f_upd(w) == 0) m_act[wr_addr - 3'd1] = wr_data;
        end
      end
      m_cnt = nc;
      m_dn  = nd;
    end
  end

  // every cycle: count and both pins against the model
  always @(negedge clk) begin
    string tc, tp;
    int w;
    if (live) begin
      w = int'(m_ctrl[3:0]);
      case (f_class(w))
        0: tc = (w == 13) ? "R5 count" : "R1 count";
        1: tc = "R6 count";
        2: tc = "R2 count";
        default: tc = "R3 count";
      endcase
      tp = (f_class(w) >= 2) ? "R8 pin" : "R1 pin";
      check(count == m_cnt, tc, count, m_cnt);
      check(out_a == f_pin(0), {tp, " A"}, out_a, f_pin(0));
      check(out_b == f_pin(1), {tp, " B"}, out_b, f_pin(1));
    end
  end

  // ---------------- stimulus helpers
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(input logic [15:0] v, input int limit);
    for (int i = 0; i < limit && count != v; i++) @(negedge clk);
  endtask

  task automatic window(input int n, output int hi_a, output int hi_b,
                        output int mx, output int mn);
    hi_a = 0; hi_b = 0; mx = 0; mn = 65535;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi_a += int'(out_a);
      hi_b += int'(out_b);
      if (int'(count) > mx) mx = int'(count);
      if (int'(count) < mn) mn = int'(count);
    end
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ha, hb, mx, mn, c0, tog;
    bit prev;
    void'($urandom(32'd4711));
    ticks(3);
    rst_n = 1'b1;
    live  = 1'b1;
    @(negedge clk);
    check(count == 0, "R10 reset count", count, 0);
    check(out_a == 0 && out_b == 0, "R10 reset pins", {out_a, out_b}, 0);

    // R4: start from stopped at /8, first step 8 clocks after the write edge
    wr(3'd0, 16'h0020);
    check(count == 0, "R4 no step at write", count, 0);
    ticks(7);
    check(count == 0, "R4 before 8th clock", count, 0);
    ticks(1);
    check(count == 1, "R4 step on 8th clock", count, 1);
    wr(3'd0, 16'h0000);

    // R1/R6: clear-on-match mode 4, TOP = compare A = 4, toggle on A
    wr(3'd1, 16'd4);
    wr(3'd0, 16'h0114);
    ticks(6);
    prev = out_a; tog = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (out_a != prev) tog++;
      prev = out_a;
    end
    check(tog == 10, "R1 toggle every 5 steps", tog, 10);

    // R4: stopped settings hold the count
    wr(3'd0, 16'h0000);
    c0 = int'(count);
    ticks(50);
    check(int'(count) == c0, "R4 select 0 holds", count, c0);
    wr(3'd0, 16'h0060);
    ticks(20);
    check(int'(count) == c0, "R4 select 6 holds", count, c0);

    // R2/R8: single slope, period register 9, compare B 3
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'd9);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h081E);
    ticks(12);
    window(10, ha, hb, mx, mn);
    check(hb == 3, "R8 fast duty 3 of 10", hb, 3);
    check(mx == 9, "R2 fast TOP 9", mx, 9);

    // R3/R8: dual slope, period register 8, compare B 3
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'd8);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h081A);
    ticks(20);
    window(16, ha, hb, mx, mn);
    check(hb == 5, "R8 dual duty 5 of 16", hb, 5);
    check(mx == 8 && mn == 0, "R3 dual span 0..8", mx * 100 + mn, 800);

    // R8: compare 0 and compare beyond TOP
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'd9);
    wr(3'd2, 16'd0);
    wr(3'd0, 16'h081E);
    ticks(5);
    window(30, ha, hb, mx, mn);
    check(hb == 0, "R8 compare 0 stays low", hb, 0);
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd12);
    wr(3'd0, 16'h081E);
    ticks(5);
    window(30, ha, hb, mx, mn);
    check(hb == 30, "R8 compare above TOP stays high", hb, 30);
    wr(3'd0, 16'h0C1E);
    ticks(5);
    window(30, ha, hb, mx, mn);
    check(hb == 0, "R8 inverted full duty stays low", hb, 0);

    // R9: buffered compare moves in at the wrap
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'd99);
    wr(3'd2, 16'd50);
    wr(3'd0, 16'h081E);
    wait_cnt(16'd10, 300);
    wr(3'd2, 16'd20);
    wait_cnt(16'd30, 300);
    check(out_b == 1'b1, "R9 old compare still active", out_b, 1);
    wait_cnt(16'd0, 300);
    wait_cnt(16'd30, 300);
    check(out_b == 1'b0, "R9 new compare after wrap", out_b, 0);

    // R7/R2: mode 15, compare A is TOP, pin A silent
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd20);
    wr(3'd0, 16'h021F);
    ticks(25);
    window(60, ha, hb, mx, mn);
    check(ha == 0, "R7 pin A silent", ha, 0);
    check(mx == 20, "R2 TOP from compare A", mx, 20);

    // R6: clear-on-match mode 12, TOP moved below the count
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'd100);
    wr(3'd0, 16'h001C);
    wait_cnt(16'd50, 70000);
    wr(3'd3, 16'd10);
    ticks(20);
    check(count > 16'd50, "R6 run past lowered TOP", count, 70);
    wait_cnt(16'd0, 70000);
    window(30, ha, hb, mx, mn);
    check(mx == 10, "R6 wraps at new TOP", mx, 10);

    // R5: reserved mode counts like mode 0
    wr(3'd0, 16'h001D);
    ticks(2);
    c0 = int'(count);
    ticks(300);
    check(count == 16'(c0 + 300), "R5 reserved free count", count, 16'(c0 + 300));

    // random mix, checked every cycle against the model (R1..R10)
    for (int s = 0; s < 250; s++) begin
      int wgm, cs, ca, cb, sel;
      wgm = int'($urandom_range(0, 15));
      sel = int'($urandom_range(0, 5));
      cs  = (sel < 3) ? 1 : (sel == 3) ? 2 : (sel == 4) ? 0 : 3;
      ca  = int'($urandom_range(0, 3));
      cb  = int'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) wr(3'd3, 16'($urandom_range(0, 400)));
      if ($urandom_range(0, 1) == 0) wr(3'd1, 16'($urandom_range(0, 450)));
      if ($urandom_range(0, 1) == 0) wr(3'd2, 16'($urandom_range(0, 450)));
      wr(3'd0, 16'(wgm | (cs << 4) | (ca << 8) | (cb << 10)));
      for (int k = 0; k < int'($urandom_range(20, 120)); k++) begin
        if ($urandom_range(0, 9) == 0)
          wr(3'($urandom_range(1, 3)), 16'($urandom_range(0, 450)));
        else
          @(negedge clk);
      end
    end

    live = 1'b0;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule